// File: doc/BRIEF.md
# Three-Pin Bidirectional GPIO Port

This block is a small general-purpose I/O port with three pins. Software on a simple processor register bus controls it through three registers. The direction register chooses, for each pin on its own, whether the pin is an input or an output. The output data latch holds the values that output pins drive. The port register returns the levels seen on the pins. The pad is modelled as an output value plus an active-high output enable, so a pin configured as an input simply has its enable low and its driver in high impedance.

The pins share their pads with analog converter inputs. A per-pin analog-select input comes from the converter configuration. A digital read of an analog-selected pin returns zero. The direction bits still decide whether the driver is on, so a pin left as an output keeps driving even while it is marked analog. Pin levels cross into the clock domain through a two-stage synchroniser before they reach the read path. Reset leaves every pin as an input with the latch cleared. The configuration source holds every pin as analog at reset, so after reset each pin is an analog input.

Top module: `tri_pin_port`

## Requirements
- R1: After reset the direction register holds 3'b111 (all pins input), the data latch holds 3'b000, `pin_oe` is 3'b000 and `pin_out` is 3'b000.
- R2: A write strobe (`wr_en` high for one cycle) to address 0 (port) or address 1 (latch) stores `wdata[2:0]` in the data latch. `pin_out` shows the new value from the clock edge that takes the write.
- R3: A read of address 1 returns the stored latch value in bits 2:0 whatever the pin levels are.
- R4: A write to address 2 stores `wdata[2:0]` as the direction bits (1 = input, 0 = output). A read of address 2 returns them, and `pin_oe[i]` is the inverse of direction bit i.
- R5: A read of address 0 returns in bits 2:0 the `pin_in` levels as they were sampled two clock edges earlier.
- R6: Every bit with `ana_sel[i]` = 1 reads as 0 through address 0. `ana_sel` has no effect on `pin_oe`, `pin_out` or reads of addresses 1 and 2.
- R7: `rdata[7:3]` is always 0. `rdata` is 0 when `rd_en` is low and for address 3. A write to address 3 changes neither the latch nor the direction register.
- R8: Read data is combinational: `rdata` is valid in the same cycle that `rd_en` and `addr` are applied, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe that qualifies `rdata` |
| addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| wdata | input | 8 | Write data; only bits 2:0 are stored |
| rdata | output | 8 | Read data, combinational |
| pin_in | input | 3 | Levels seen at the pads |
| ana_sel | input | 3 | Per-pin analog select from the converter configuration |
| pin_out | output | 3 | Values driven onto the pads |
| pin_oe | output | 3 | Per-pin output enable; 0 means high impedance |

## Verification
Register reads are due in the same cycle as the strobe. The bench drives each read on the falling edge and samples `rdata` 4 ns later, before the next rising edge. Writes show up one rising edge later, on `pin_out`, `pin_oe` and on a read in the next cycle, and the bench checks `pin_out` on both sides of that edge. A change on `pin_in` reaches a port read only after two rising edges. The bench reads the port in the cycle of the change, one edge later and two edges later, and expects the old value, the old value and then the new value. It holds the pins steady for two cycles before every other port read.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
  typedef enum logic [1:0] {
    REG_PORT  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio3_regs.sv
module gpio3_regs
  import gpio3_pkg::*;
#(
  parameter int PINS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [PINS-1:0] wval,
  output logic [PINS-1:0] lat_q,
  output logic [PINS-1:0] dir_q
);
  logic hit_lat, hit_dir;

  assign hit_lat = wr_en && ((addr == REG_PORT) || (addr == REG_LATCH));
  assign hit_dir = wr_en && (addr == REG_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (hit_lat) lat_q <= wval;
      if (hit_dir) dir_q <= wval;
    end
  end

  // R2: a latch write through either address lands on the next edge
  p_latch_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == REG_PORT || addr == REG_LATCH)) |=> (lat_q == $past(wval)));

  // R4: direction only moves on its own address
  p_dir_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == REG_DIR) |=> $stable(dir_q));

  // R7: the unused address writes nothing
  p_none_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_NONE) |=> ($stable(lat_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio3_sync.sv
module gpio3_sync #(
  parameter int PINS   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);
  logic [STAGES-1:0][PINS-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio3_rdmux.sv
module gpio3_rdmux
  import gpio3_pkg::*;
#(
  parameter int PINS = 3,
  parameter int DW   = 8
) (
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [PINS-1:0] pin_sync,
  input  logic [PINS-1:0] ana_sel,
  input  logic [PINS-1:0] lat_q,
  input  logic [PINS-1:0] dir_q,
  output logic [DW-1:0]   rdata
);
  logic [PINS-1:0] port_val;

  genvar b;
  generate
    for (b = 0; b < PINS; b++) begin : g_mask
      assign port_val[b] = ana_sel[b] ? 1'b0 : pin_sync[b];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        REG_PORT:  rdata[PINS-1:0] = port_val;
        REG_LATCH: rdata[PINS-1:0] = lat_q;
        REG_DIR:   rdata[PINS-1:0] = dir_q;
        default:   rdata = '0;
      endcase
    end
  end

  // R6: analog bits never leak into a port read
  always_comb begin
    if (rd_en && addr == REG_PORT) begin
      p_ana_zero_r6: assert ((rdata[PINS-1:0] & ana_sel) == '0);
    end
  end
endmodule

// File: rtl/tri_pin_port.sv
module tri_pin_port
  import gpio3_pkg::*;
#(
  parameter int PINS        = 3,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] ana_sel,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  localparam int WARM_W = $clog2(SYNC_STAGES + 1);
  localparam logic [WARM_W-1:0] WARM_MAX = WARM_W'(SYNC_STAGES);

  logic [PINS-1:0] lat_q, dir_q, pin_sync;

  gpio3_regs #(.PINS(PINS)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wval  (wdata[PINS-1:0]),
    .lat_q (lat_q),
    .dir_q (dir_q)
  );

  gpio3_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio3_rdmux #(.PINS(PINS), .DW(DW)) u_rdmux (
    .rd_en    (rd_en),
    .addr     (addr),
    .pin_sync (pin_sync),
    .ana_sel  (ana_sel),
    .lat_q    (lat_q),
    .dir_q    (dir_q),
    .rdata    (rdata)
  );

  assign pin_out = lat_q;
  assign pin_oe  = ~dir_q;

  // cycles since reset, saturating, so port-read checks look back only over live history
  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                    warm_q <= '0;
    else if (warm_q != WARM_MAX) warm_q <= warm_q + 1'b1;
  end

  // R5: port read shows the pins from SYNC_STAGES edges back, masked by analog select
  p_port_delay_r5: assert property (@(posedge clk) disable iff (rst)
    (warm_q == WARM_MAX && rd_en && addr == REG_PORT) |->
      (rdata[PINS-1:0] == ($past(pin_in, SYNC_STAGES) & ~ana_sel)));

  // R4: direction readback and output enable agree
  p_oe_dir_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_DIR) |-> (rdata[PINS-1:0] == ~pin_oe));

  // R7: upper data bits stay zero and an idle bus reads zero
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1:PINS] == '0);
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rdata == '0));

  // R1: the first cycle after reset has every driver off
  p_reset_state_r1: assert property (@(posedge clk)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/tri_pin_port_test.sv
module tri_pin_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] pin_in = 3'd0, ana_sel = 3'b111;
  logic [2:0] pin_out, pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_pin_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .ana_sel(ana_sel),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {is_read, addr[1:0], data[7:0], pins[2:0], ana[2:0]}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'd1, 8'h05, 3'd0, 3'd0},  // R2 latch write
    {1'b1, 2'd1, 8'h05, 3'd0, 3'd0},  // R3 latch read
    {1'b0, 2'd2, 8'h02, 3'd0, 3'd0},  // R4 direction write
    {1'b1, 2'd2, 8'h02, 3'd0, 3'd0},  // R4 direction read
    {1'b0, 2'd0, 8'hFA, 3'd0, 3'd0},  // R2 write via port address
    {1'b1, 2'd1, 8'h02, 3'd0, 3'd0},  // R2 latch now 2
    {1'b1, 2'd1, 8'h02, 3'd6, 3'd0},  // R3 pins change, latch read unaffected
    {1'b1, 2'd1, 8'h02, 3'd6, 3'd0},  // R3
    {1'b1, 2'd0, 8'h06, 3'd6, 3'd0},  // R5 port read after two edges
    {1'b1, 2'd0, 8'h04, 3'd6, 3'd2},  // R6 bit 1 analog
    {1'b1, 2'd0, 8'h00, 3'd6, 3'd6},  // R6 bits 2,1 analog
    {1'b0, 2'd3, 8'hFF, 3'd6, 3'd0},  // R7 unused address write
    {1'b1, 2'd2, 8'h02, 3'd6, 3'd0},  // R7 direction kept
    {1'b1, 2'd1, 8'h02, 3'd6, 3'd7},  // R7 latch kept, R6 latch read ignores analog
    {1'b1, 2'd3, 8'h00, 3'd6, 3'd0}   // R7 unused address reads zero
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R8 same-cycle reads
    #4;
    chk("R1 pin_oe", {5'd0, pin_oe}, 8'h00);
    chk("R1 pin_out", {5'd0, pin_out}, 8'h00);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd2; #4;
    chk("R1 dir reset", rdata, 8'h07);
    @(negedge clk);
    addr = 2'd1; #4;
    chk("R1 latch reset", rdata, 8'h00);
    @(negedge clk);
    pin_in = 3'd7; addr = 2'd0;
    @(negedge clk);
    @(negedge clk); #4;
    chk("R6 all analog after reset", rdata, 8'h00);
    @(negedge clk);
    rd_en = 1'b0; pin_in = 3'd0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      addr    = v[15:14];
      pin_in  = v[5:3];
      ana_sel = v[2:0];
      rd_en   = v[16];
      wr_en   = !v[16];
      wdata   = v[16] ? 8'h00 : v[13:6];
      #4;
      if (v[16]) chk($sformatf("vector %0d (R3 R5 R6 R7 R8)", i), rdata, v[13:6]);
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;

    // R6: drivers follow direction even with all pins analog
    ana_sel = 3'b111; #4;
    chk("R6 oe under analog", {5'd0, pin_oe}, 8'h05);
    chk("R6 out under analog", {5'd0, pin_out}, 8'h02);
    // R7: no read strobe, no data
    addr = 2'd1; #1;
    chk("R7 idle bus", rdata, 8'h00);
    @(negedge clk);

    // R2: pin_out changes at the edge that takes the write
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h07; #4;
    chk("R2 before edge", {5'd0, pin_out}, 8'h02);
    @(posedge clk); #1;
    chk("R2 after edge", {5'd0, pin_out}, 8'h07);
    @(negedge clk);
    wr_en = 1'b0;

    // R5: two-edge latency on port reads
    ana_sel = 3'b000; pin_in = 3'd1; rd_en = 1'b1; addr = 2'd0; #4;
    chk("R5 edge 0", rdata, 8'h06);
    @(negedge clk); #4;
    chk("R5 edge 1", rdata, 8'h06);
    @(negedge clk); #4;
    chk("R5 edge 2", rdata, 8'h01);
    @(negedge clk);
    rd_en = 1'b0;

    // R4: clearing direction turns every driver on
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; #4;
    chk("R4 all outputs", {5'd0, pin_oe}, 8'h07);
    rd_en = 1'b1; #1;
    chk("R4 dir readback", rdata, 8'h00);
    @(negedge clk);
    rd_en = 1'b0;

    finish_run();
  end
endmodule